// File: doc/BRIEF.md
# Phrase Memory Controller with Region Remap

This block sits between a bus master and three kinds of storage in a 24-bit byte address space: DRAM, a cartridge ROM port, and an internal space made of boot ROM and on-chip peripherals. The master issues one 64-bit phrase read or write at a time over a valid/ready request port. The block decodes the address into a region and a masked offset, strobes a single backend port for that region, and returns the read data together with the number of cycles the access cost. The request port stays busy for exactly that many cycles, so the cost is what the bus pays.

A 16-bit configuration register is written over its own port. One bit of it swaps the places of DRAM and cartridge in the map. A two-bit field sets the cartridge access time. Until the register is written for the first time after reset, every phrase access goes to internal space. Inside internal space, addresses outside the peripheral window are boot ROM, which cannot be written. Peripheral addresses outside the handled sub-window read back as all ones and are never forwarded.

The backend is read without delay: it returns `be_rdata` in the same cycle as `be_valid`. A phrase holds four 16-bit words, and the word at the lowest address sits in bits 63:48. The backend must deliver data in that order. The block captures the data as it stands.

Top module: `phrase_mem_ctrl`

## Requirements
- R1: Until the first configuration write after reset, every phrase access is decoded as internal space and costs 2 cycles.
- R2: With configuration bit 0 set, aligned addresses below 0x800000 are DRAM, addresses from 0x800000 up to below 0xE00000 are cartridge, and the rest are internal.
- R3: With configuration bit 0 clear, aligned addresses strictly above 0x800000 are DRAM, addresses strictly above 0x200000 up to 0x800000 are cartridge, and addresses up to and including 0x200000 are internal.
- R4: Configuration bits 4:3 give a cartridge cycle count of 10, 8, 6 or 5 for field values 0, 1, 2 or 3. A cartridge access costs twice that count. DRAM and internal accesses cost 2.
- R5: A configuration write takes effect on the very next clock edge, so a request accepted on the edge after the write uses the new value.
- R6: A request is accepted in a cycle with `req_valid` and `req_ready` both high. If that is cycle 0 and the cost is C, then `req_ready` is low in cycles 1..C, `rsp_valid` is high only in cycle C, and `req_ready` is high again in cycle C+1.
- R7: Internal addresses outside 0x100000–0x11FFFF are boot ROM. A write there produces no backend strobe.
- R8: Internal addresses inside 0x100000–0x11FFFF but outside the handled window 0x100000–0x117FFF are unmapped. Reads there return 0xFFFF in all four words. Neither reads nor writes there produce a backend strobe.
- R9: The phrase address has its low 3 bits forced to zero. The backend offset is that address masked to 2 MiB for DRAM, 4 MiB for cartridge and 128 KiB for boot ROM, and left unmasked for peripherals.
- R10: In the accept cycle, `be_valid` rises together with `be_region`, which is 0 for DRAM, 1 for cartridge, 2 for boot ROM and 3 for peripheral, along with the offset, `be_we` and `be_wdata`. The read data on `rsp_rdata` is the `be_rdata` value of that cycle. A write returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Phrase request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 24 | Byte address of the phrase |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write phrase, lowest-addressed word in 63:48 |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 64 | Read phrase (zero for writes) |
| rsp_cost | output | 5 | Cycle cost of the access, valid with rsp_valid |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| be_valid | output | 1 | Backend access strobe |
| be_region | output | 2 | Backend target: 0 DRAM, 1 cartridge, 2 boot ROM, 3 peripheral |
| be_offset | output | 24 | Masked byte offset within the region |
| be_we | output | 1 | Backend write |
| be_wdata | output | 64 | Backend write phrase |
| be_rdata | input | 64 | Backend read phrase, same cycle as be_valid |

## Verification
The backend strobe, region, offset and write data are combinational from the request, so they are sampled in the accept cycle itself, away from the clock edge. The response is due a number of cycles after acceptance equal to the access cost. The bench samples `rsp_valid` and `req_ready` at every falling edge from acceptance until the idle cycle that follows. It requires the pulse at exactly the computed cycle and nowhere else. Configuration writes are placed right before a request, so that accepting the request on the next edge shows that the new wait-state and remap values are already in use.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    RG_DRAM = 2'd0,
    RG_CART = 2'd1,
    RG_BOOT = 2'd2,
    RG_PERI = 2'd3
  } region_e;

  localparam int COST_W = 5;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pmc_cfg_reg.sv
module pmc_cfg_reg #(
  parameter int CFG_W     = 16,
  parameter int REMAP_BIT = 0,
  parameter int WS_LSB    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             remap_hi,
  output logic             cfg_seen,
  output logic [3:0]       cart_cyc
);
  logic       remap_q, remap_d;
  logic [1:0] ws_q, ws_d;
  logic       seen_q, seen_d;

  always_comb begin
    remap_d = remap_q;
    ws_d    = ws_q;
    seen_d  = seen_q;
    if (cfg_we) begin
      remap_d = cfg_wdata[REMAP_BIT];
      ws_d    = cfg_wdata[WS_LSB +: 2];
      seen_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_q <= 1'b0;
      ws_q    <= 2'd0;
      seen_q  <= 1'b0;
    end else if (cfg_we) begin
      remap_q <= remap_d;
      ws_q    <= ws_d;
      seen_q  <= seen_d;
    end
  end

  always_comb begin
    unique case (ws_q)
      2'd0:    cart_cyc = 4'd10;
      2'd1:    cart_cyc = 4'd8;
      2'd2:    cart_cyc = 4'd6;
      default: cart_cyc = 4'd5;
    endcase
  end

  assign remap_hi = remap_q;
  assign cfg_seen = seen_q;
endmodule

// File: rtl/pmc_decode.sv
module pmc_decode
  import pmc_pkg::*;
#(
  parameter int          ADDR_W  = 24,
  parameter int          DRAM_AW = 21,
  parameter int          CART_AW = 22,
  parameter int          BOOT_AW = 17,
  parameter int unsigned MAP_LO  = 32'h200000,
  parameter int unsigned MAP_MID = 32'h800000,
  parameter int unsigned MAP_HI  = 32'hE00000,
  parameter int unsigned INT_LO  = 32'h100000,
  parameter int unsigned INT_HI  = 32'h120000,
  parameter int unsigned LIVE_LO = 32'h100000,
  parameter int unsigned LIVE_HI = 32'h118000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              remap_hi,
  input  logic              cfg_seen,
  input  logic [3:0]        cart_cyc,
  output region_e           region,
  output logic [ADDR_W-1:0] offset,
  output logic              fwd,
  output logic              unmapped,
  output logic [COST_W-1:0] cost
);
  localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(MAP_LO);
  localparam logic [ADDR_W-1:0] MID_A  = ADDR_W'(MAP_MID);
  localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(MAP_HI);
  localparam logic [ADDR_W-1:0] ILO_A  = ADDR_W'(INT_LO);
  localparam logic [ADDR_W-1:0] IHI_A  = ADDR_W'(INT_HI);
  localparam logic [ADDR_W-1:0] LLO_A  = ADDR_W'(LIVE_LO);
  localparam logic [ADDR_W-1:0] LHI_A  = ADDR_W'(LIVE_HI);
  localparam logic [ADDR_W-1:0] DRAM_M = {{(ADDR_W-DRAM_AW){1'b0}}, {DRAM_AW{1'b1}}};
  localparam logic [ADDR_W-1:0] CART_M = {{(ADDR_W-CART_AW){1'b0}}, {CART_AW{1'b1}}};
  localparam logic [ADDR_W-1:0] BOOT_M = {{(ADDR_W-BOOT_AW){1'b0}}, {BOOT_AW{1'b1}}};

  logic to_int;

  always_comb begin
    to_int   = 1'b0;
    region   = RG_BOOT;
    unmapped = 1'b0;
    if (!cfg_seen) begin
      to_int = 1'b1;
    end else if (remap_hi) begin
      if (addr < MID_A)     region = RG_DRAM;
      else if (addr < HI_A) region = RG_CART;
      else                  to_int = 1'b1;
    end else begin
      if (addr > MID_A)     region = RG_DRAM;
      else if (addr > LO_A) region = RG_CART;
      else                  to_int = 1'b1;
    end
    if (to_int) begin
      if (addr < ILO_A || addr >= IHI_A) begin
        region = RG_BOOT;
      end else begin
        region   = RG_PERI;
        unmapped = !(addr >= LLO_A && addr < LHI_A);
      end
    end
  end

  always_comb begin
    unique case (region)
      RG_DRAM: offset = addr & DRAM_M;
      RG_CART: offset = addr & CART_M;
      RG_BOOT: offset = addr & BOOT_M;
      default: offset = addr;
    endcase
  end

  assign fwd  = !unmapped && !(region == RG_BOOT && we);
  assign cost = (region == RG_CART) ? {cart_cyc, 1'b0} : COST_W'(2);
endmodule

// File: rtl/pmc_resp.sv
module pmc_resp
  import pmc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [COST_W-1:0] load_cost,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [COST_W-1:0] rsp_cost
);
  logic              busy_q, busy_d;
  logic [COST_W-1:0] cnt_q, cnt_d;
  logic [COST_W-1:0] cost_q, cost_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              upd_en;

  assign upd_en = accept | busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cost_d = cost_q;
    data_d = data_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = load_cost - COST_W'(1);
      cost_d = load_cost;
      data_d = load_data;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - COST_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cost_q <= '0;
      data_q <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      cost_q <= cost_d;
      data_q <= data_d;
    end
  end

  assign busy      = busy_q;
  assign rsp_valid = busy_q && (cnt_q == '0);
  assign rsp_rdata = data_q;
  assign rsp_cost  = cost_q;
endmodule

// File: rtl/phrase_mem_ctrl.sv
module phrase_mem_ctrl
  import pmc_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 64,
  parameter int CFG_W   = 16,
  parameter int DRAM_AW = 21,
  parameter int CART_AW = 22,
  parameter int BOOT_AW = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [COST_W-1:0] rsp_cost,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              be_valid,
  output logic [1:0]        be_region,
  output logic [ADDR_W-1:0] be_offset,
  output logic              be_we,
  output logic [DATA_W-1:0] be_wdata,
  input  logic [DATA_W-1:0] be_rdata
);
  localparam int ALIGN_W = $clog2(DATA_W / 8);

  logic              rst_n_i;
  logic              remap_hi, cfg_seen;
  logic [3:0]        cart_cyc;
  logic [ADDR_W-1:0] addr_al;
  region_e           region;
  logic              fwd, unmapped, busy, accept;
  logic [COST_W-1:0] cost;
  logic [DATA_W-1:0] load_data;
  logic              unused_ok;

  pmc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  pmc_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_i), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .remap_hi(remap_hi), .cfg_seen(cfg_seen), .cart_cyc(cart_cyc)
  );

  assign addr_al = {req_addr[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};

  pmc_decode #(
    .ADDR_W(ADDR_W), .DRAM_AW(DRAM_AW), .CART_AW(CART_AW), .BOOT_AW(BOOT_AW)
  ) u_dec (
    .addr(addr_al), .we(req_we), .remap_hi(remap_hi), .cfg_seen(cfg_seen),
    .cart_cyc(cart_cyc), .region(region), .offset(be_offset), .fwd(fwd),
    .unmapped(unmapped), .cost(cost)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign be_valid  = accept && fwd;
  assign be_region = region;
  assign be_we     = req_we;
  assign be_wdata  = req_wdata;

  always_comb begin
    if (req_we)        load_data = '0;
    else if (unmapped) load_data = '1;
    else               load_data = be_rdata;
  end

  pmc_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n_i), .accept(accept), .load_cost(cost),
    .load_data(load_data), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_cost(rsp_cost)
  );

  assign unused_ok = &{1'b0, req_addr[ALIGN_W-1:0]};
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       be_valid,
  input logic [1:0] be_region,
  input logic       be_we,
  input logic       rsp_valid,
  input logic [4:0] rsp_cost,
  input logic       cfg_we
);
  logic seen_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_c <= 1'b0;
    else if (cfg_we) seen_c <= 1'b1;
  end

  // R10: a backend strobe only in an accept cycle
  a_r10_strobe_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    be_valid |-> (req_valid && req_ready));

  // R7: boot ROM never receives a write
  a_r7_no_boot_write: assert property (@(posedge clk) disable iff (!rst_n)
    (be_valid && be_region == 2'd2) |-> !be_we);

  // R1: before configuration only internal regions are targeted
  a_r1_internal_first: assert property (@(posedge clk) disable iff (!rst_n)
    (be_valid && !seen_c) |-> be_region[1]);

  // R6: accepted request makes the port busy on the next cycle
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R6: response is a one-cycle pulse followed by an idle port
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R4: reported cost is one of the legal charges
  a_r4_cost_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cost inside {5'd2, 5'd10, 5'd12, 5'd16, 5'd20}));
endmodule

bind phrase_mem_ctrl pmc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .be_valid(be_valid), .be_region(be_region), .be_we(be_we),
  .rsp_valid(rsp_valid), .rsp_cost(rsp_cost), .cfg_we(cfg_we)
);

// File: tb/tb_phrase_mem_ctrl.sv
`timescale 1ns/1ps
module tb_phrase_mem_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic [4:0]  rsp_cost;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        be_valid;
  logic [1:0]  be_region;
  logic [23:0] be_offset;
  logic        be_we;
  logic [63:0] be_wdata;
  logic [63:0] be_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit          seen_m = 1'b0;
  logic [15:0] cfg_m = '0;

  always #2 clk = ~clk;

  function automatic logic [63:0] bk_data(input logic [1:0] rg, input logic [23:0] off);
    return {6'd0, rg, off, ~off[15:0], 16'h5A3C};
  endfunction

  assign be_rdata = bk_data(be_region, be_offset);

  phrase_mem_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_cost(rsp_cost),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .be_valid(be_valid),
    .be_region(be_region), .be_offset(be_offset), .be_we(be_we),
    .be_wdata(be_wdata), .be_rdata(be_rdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // Behavioural expectation of a request, from the requirements.
  task automatic expect_of(input int unsigned a, input bit we,
                           output int rg, output int unsigned off,
                           output bit fwd, output bit unm, output int cost);
    int cc[4] = '{10, 8, 6, 5};
    bit inside_int;
    rg = -1;
    unm = 0;
    if (!seen_m)         inside_int = 1;
    else if (cfg_m[0]) begin
      if (a < 'h800000)      begin rg = 0; inside_int = 0; end
      else if (a < 'hE00000) begin rg = 1; inside_int = 0; end
      else                   inside_int = 1;
    end else begin
      if (a > 'h800000)      begin rg = 0; inside_int = 0; end
      else if (a > 'h200000) begin rg = 1; inside_int = 0; end
      else                   inside_int = 1;
    end
    if (inside_int) begin
      if (a >= 'h100000 && a < 'h120000) begin
        rg = 3;
        unm = !(a < 'h118000);
      end else rg = 2;
    end
    case (rg)
      0: off = a % 'h200000;
      1: off = a % 'h400000;
      2: off = a % 'h20000;
      default: off = a;
    endcase
    fwd  = !unm && !(rg == 2 && we);
    cost = (rg == 1) ? 2 * cc[cfg_m[4:3]] : 2;
  endtask

  // Entered and left at a falling edge.
  task automatic cfg_write(input logic [15:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_m = v;
    seen_m = 1'b1;
  endtask

  task automatic access(input string req, input logic [23:0] addr, input bit we,
                        input logic [63:0] wd);
    int unsigned a, off;
    int rg, cost;
    bit fwd, unm;
    logic [63:0] exp_d;
    a = {addr[23:3], 3'b000};
    expect_of(a, we, rg, off, fwd, unm, cost);
    req_valid = 1'b1;
    req_addr  = addr;
    req_we    = we;
    req_wdata = wd;
    #1;
    chk({req, " R6 ready at accept"}, 64'(req_ready), 64'd1);
    chk({req, " R10 strobe"}, 64'(be_valid), 64'(fwd));
    if (fwd) begin
      chk({req, " R10 region"}, 64'(be_region), 64'(rg));
      chk({req, " R9 offset"}, 64'(be_offset), 64'(off));
      chk({req, " R10 we"}, 64'(be_we), 64'(we));
      if (we) chk({req, " R10 wdata"}, be_wdata, wd);
    end
    if (we)       exp_d = '0;
    else if (unm) exp_d = '1;
    else          exp_d = bk_data(2'(rg), 24'(off));
    @(negedge clk);
    req_valid = 1'b0;
    for (int j = 0; j < cost; j++) begin
      chk({req, " R6 rsp pulse timing"}, 64'(rsp_valid), 64'(j == cost - 1));
      chk({req, " R6 busy"}, 64'(req_ready), 64'd0);
      if (j == cost - 1) begin
        chk({req, " R4 cost"}, 64'(rsp_cost), 64'(cost));
        chk({req, " R10 rdata"}, rsp_rdata, exp_d);
      end
      if (!rsp_valid && j == cost - 1) break;
      @(negedge clk);
    end
    if (rsp_valid) @(negedge clk);
    chk({req, " R6 idle again"}, 64'({req_ready, rsp_valid}), 64'b10);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset ready", 64'(req_ready), 64'd1);
    chk("R6 reset rsp", 64'(rsp_valid), 64'd0);
    chk("R10 reset strobe", 64'(be_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: before any configuration write
    access("R1 boot read", 24'h9123AD, 1'b0, '0);
    access("R1 peri read", 24'h100040, 1'b0, '0);
    access("R7 boot write drop", 24'h000010, 1'b1, 64'h1111_2222_3333_4444);

    // R2 with remap bit set, wait field 0 (cost 20)
    cfg_write(16'h0001);
    access("R2 dram low", 24'h000100, 1'b0, '0);
    access("R2 dram top", 24'h7FFFF8, 1'b0, '0);
    access("R2 cart start R5", 24'h800000, 1'b0, '0);
    access("R2 cart end", 24'hDFFFF8, 1'b0, '0);
    access("R2 internal boot", 24'hE00000, 1'b0, '0);
    access("R2 dram write", 24'h012346, 1'b1, 64'hDEAD_BEEF_0123_4567);

    // R3 with remap bit clear, wait field 3 (cost 10)
    cfg_write(16'h0018);
    access("R3 cart at split", 24'h800000, 1'b0, '0);
    access("R3 dram above", 24'h800008, 1'b0, '0);
    access("R9 dram mask", 24'hFFFFF8, 1'b0, '0);
    access("R3 internal at low", 24'h200000, 1'b0, '0);
    access("R3 cart above low", 24'h200008, 1'b0, '0);
    access("R8 peri write", 24'h104000, 1'b1, 64'hCAFE_F00D_0000_0001);
    access("R8 unmapped read", 24'h11C000, 1'b0, '0);
    access("R8 unmapped write", 24'h11FFF8, 1'b1, 64'h5);
    access("R7 boot write remapped", 24'h020000, 1'b1, 64'h6);

    // R4 / R5: other wait fields, used on the first request after the write
    cfg_write(16'h0008);
    access("R4 R5 ws1", 24'h300000, 1'b0, '0);
    cfg_write(16'h0010);
    access("R4 R5 ws2", 24'h3ABCD8, 1'b1, 64'h0F0F_0F0F_F0F0_F0F0);
    cfg_write(16'h0019);
    access("R4 R2 ws3 remap", 24'hA00000, 1'b0, '0);

    finish_run();
  end
endmodule